// File: doc/BRIEF.md
# Program Counter with Dedicated Return Stack

This block keeps the 16-bit program counter of a small controller core and a return stack held in its own 256-byte RAM. The RAM is separate from the general data RAM. Each cycle the surrounding core can ask the block to do one of several things: step the counter past the instruction just executed, load a jump target, enter a subroutine, take an interrupt vector, or come back from a subroutine. Software can also move the stack pointer by writing it directly.

Entering a subroutine or an interrupt saves a two-byte return address on the stack. Returning restores it. The stack is one byte wide, so every save and every restore takes two back-to-back stack cycles. During the second of these cycles the block raises `busy` and takes no new request. The stack memory port is visible at the outputs, so the core and the bench can watch each access as it happens.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `pc` is 0x0000, `sp` is 0x07 and `busy` is 0.
- R2: An idle cycle in which only `adv_valid` is set adds `instr_len` (encoding: the unsigned value 1, 2 or 3) to `pc` at the next edge. The sum wraps modulo 65536.
- R3: An idle cycle in which `jmp_valid` is the highest request loads `jmp_target` into `pc` at the next edge.
- R4: A granted call loads `call_target` into `pc` at the next edge. It saves the return address `pc + instr_len`: the low byte goes to address `sp+1` in the grant cycle and the high byte to the address one above that in the following cycle. `sp` rises by one in each of the two cycles.
- R5: A granted vector request loads `vec_target` into `pc` at the next edge. It saves the unchanged current `pc` with the same two-cycle byte order as R4.
- R6: A granted return reads the high byte at `sp` and decrements `sp`. In the next cycle it reads the low byte at the new `sp` and decrements `sp` again. `pc` takes the restored address at the edge that ends that second cycle.
- R7: When requests coincide in an idle cycle, only the highest one takes effect. The order from highest to lowest is vector, call, return, jump, advance.
- R8: `busy` is 1 for exactly the one cycle after a granted call, vector or return. In that cycle every request and any stack pointer write is ignored.
- R9: `sp_wr_en` loads `sp_wr_data` into `sp` only in an idle cycle in which no call, vector or return is granted. Otherwise the write is dropped. A jump or advance in the same cycle still takes effect.
- R10: `sp` wraps modulo 256 with no error indication: a push from 0xFF writes address 0x00, and a pop at 0x00 leaves 0xFF.
- R11: `stk_we` is 1 exactly in the two cycles of each push pair. In those cycles `stk_addr` is `sp+1`; in every other cycle it is `sp`. `stk_wdata` carries the byte being written, and `stk_rdata` shows the stored byte at `stk_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_valid | input | 1 | Step the counter by `instr_len` |
| instr_len | input | 2 | Length in bytes of the current instruction (1 to 3) |
| jmp_valid | input | 1 | Jump request |
| jmp_target | input | 16 | Jump destination |
| call_valid | input | 1 | Subroutine call request |
| call_target | input | 16 | Call destination |
| ret_valid | input | 1 | Return request |
| vec_valid | input | 1 | Interrupt vector request |
| vec_target | input | 16 | Interrupt vector address |
| sp_wr_en | input | 1 | Direct stack pointer write |
| sp_wr_data | input | 8 | Value for the stack pointer write |
| pc | output | 16 | Current program counter |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Second cycle of a push or pop pair; requests ignored |
| stk_we | output | 1 | Stack memory write strobe |
| stk_addr | output | 8 | Stack memory address of the current access |
| stk_wdata | output | 8 | Stack memory write byte |
| stk_rdata | output | 8 | Stack memory byte at `stk_addr` |

## Verification
The hardest situation to reach from the ports is a push or pop pair that straddles the wrap of the stack pointer, combined with a full set of requests that arrive while `busy` is high. The bench first writes the stack pointer to 0xFE or 0xFF, then issues a call or vector so that the two bytes land on both sides of address 0x00, and returns across the same boundary. In the second stack cycle it drives every request together with a stack pointer write. A long stretch of mixed random requests follows, with returns allowed only while the behavioural model knows the stack holds a saved address.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // Which request wins in an idle cycle (ordered low to high priority)
   typedef enum logic [2:0] {
      GR_NONE = 3'd0,
      GR_ADV  = 3'd1,
      GR_JMP  = 3'd2,
      GR_RET  = 3'd3,
      GR_CALL = 3'd4,
      GR_VEC  = 3'd5
   } grant_e;

   // Stack sequencer phase
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_PUSH2 = 2'd1,
      SQ_POP2  = 2'd2
   } seq_e;

   function automatic logic grant_uses_stack(grant_e g);
      return (g == GR_CALL) || (g == GR_VEC) || (g == GR_RET);
   endfunction

endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
   import pcs_pkg::*;
(
   input  logic   enable,
   input  logic   vec_req,
   input  logic   call_req,
   input  logic   ret_req,
   input  logic   jmp_req,
   input  logic   adv_req,
   output grant_e grant
);

   // Fixed priority: vector > call > return > jump > advance
   always_comb begin
      grant = GR_NONE;
      if (enable) begin
         if (vec_req)       grant = GR_VEC;
         else if (call_req) grant = GR_CALL;
         else if (ret_req)  grant = GR_RET;
         else if (jmp_req)  grant = GR_JMP;
         else if (adv_req)  grant = GR_ADV;
      end
   end

endmodule

// File: rtl/pcs_stack_ram.sv
module pcs_stack_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
   end

   // Asynchronous read so a pop completes in the cycle it addresses
   assign rdata = mem_q[addr];

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
   import pcs_pkg::*;
#(
   parameter int               PC_W     = 16,
   parameter int               BYTE_W   = 8,
   parameter int               SP_W     = 8,
   parameter logic [SP_W-1:0]  SP_RST   = 8'h07,
   parameter bit               LO_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  grant_e            grant,
   input  logic [PC_W-1:0]   ret_addr,
   input  logic              sp_wr_en,
   input  logic [SP_W-1:0]   sp_wr_data,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic [SP_W-1:0]   sp_q,
   output logic              busy,
   output logic              mem_we,
   output logic [SP_W-1:0]   mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              pop_done,
   output logic [PC_W-1:0]   pop_pc
);

   localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

   seq_e              state_q, state_d;
   logic [SP_W-1:0]   sp_d;
   logic [BYTE_W-1:0] held_q, held_d;
   logic [BYTE_W-1:0] first_byte, second_byte;
   logic              start_push, start_pop;

   // Byte order variant: which half of the return address goes first
   generate
      if (LO_FIRST) begin : g_lo_first
         assign first_byte  = ret_addr[BYTE_W-1:0];
         assign second_byte = ret_addr[PC_W-1:BYTE_W];
         assign pop_pc      = {held_q, rd_byte};
      end else begin : g_hi_first
         assign first_byte  = ret_addr[PC_W-1:BYTE_W];
         assign second_byte = ret_addr[BYTE_W-1:0];
         assign pop_pc      = {rd_byte, held_q};
      end
   endgenerate

   assign start_push = (state_q == SQ_IDLE) && ((grant == GR_CALL) || (grant == GR_VEC));
   assign start_pop  = (state_q == SQ_IDLE) && (grant == GR_RET);
   assign busy       = (state_q != SQ_IDLE);
   assign pop_done   = (state_q == SQ_POP2);

   // Memory port: pushes pre-increment, pops read at the current pointer
   always_comb begin
      mem_we    = start_push || (state_q == SQ_PUSH2);
      mem_addr  = mem_we ? (sp_q + SP_ONE) : sp_q;
      mem_wdata = (state_q == SQ_PUSH2) ? held_q : first_byte;
   end

   always_comb begin
      state_d = state_q;
      sp_d    = sp_q;
      held_d  = held_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (start_push) begin
               sp_d    = sp_q + SP_ONE;
               held_d  = second_byte;
               state_d = SQ_PUSH2;
            end else if (start_pop) begin
               sp_d    = sp_q - SP_ONE;
               held_d  = rd_byte;
               state_d = SQ_POP2;
            end else if (sp_wr_en) begin
               sp_d = sp_wr_data;
            end
         end
         SQ_PUSH2: begin
            sp_d    = sp_q + SP_ONE;
            state_d = SQ_IDLE;
         end
         SQ_POP2: begin
            sp_d    = sp_q - SP_ONE;
            state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         sp_q    <= SP_RST;
         held_q  <= '0;
      end else begin
         state_q <= state_d;
         sp_q    <= sp_d;
         held_q  <= held_d;
      end
   end

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
   import pcs_pkg::*;
#(
   parameter int              PC_W     = 16,
   parameter int              BYTE_W   = 8,
   parameter int              SP_W     = 8,
   parameter int              LEN_W    = 2,
   parameter logic [SP_W-1:0] SP_RST   = 8'h07,
   parameter bit              LO_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_valid,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic              jmp_valid,
   input  logic [PC_W-1:0]   jmp_target,
   input  logic              call_valid,
   input  logic [PC_W-1:0]   call_target,
   input  logic              ret_valid,
   input  logic              vec_valid,
   input  logic [PC_W-1:0]   vec_target,
   input  logic              sp_wr_en,
   input  logic [SP_W-1:0]   sp_wr_data,
   output logic [PC_W-1:0]   pc,
   output logic [SP_W-1:0]   sp,
   output logic              busy,
   output logic              stk_we,
   output logic [SP_W-1:0]   stk_addr,
   output logic [BYTE_W-1:0] stk_wdata,
   output logic [BYTE_W-1:0] stk_rdata
);

   // Elaboration-time parameter checks
   generate
      if (PC_W != 2 * BYTE_W) begin : g_bad_pc_w
         $error("pc_stack_unit: PC_W must be two stack bytes wide");
      end
      if (SP_W < 1 || SP_W > 12) begin : g_bad_sp_w
         $error("pc_stack_unit: SP_W out of range");
      end
      if (LEN_W < 1 || LEN_W >= PC_W) begin : g_bad_len_w
         $error("pc_stack_unit: LEN_W out of range");
      end
   endgenerate

   grant_e            grant;
   logic [PC_W-1:0]   pc_q, pc_d;
   logic [PC_W-1:0]   next_seq_pc;
   logic [PC_W-1:0]   ret_addr;
   logic              seq_busy;
   logic              pop_done;
   logic [PC_W-1:0]   pop_pc;
   logic              mem_we;
   logic [SP_W-1:0]   mem_addr;
   logic [BYTE_W-1:0] mem_wdata;
   logic [BYTE_W-1:0] mem_rdata;
   logic [SP_W-1:0]   sp_q;

   pcs_arbiter u_arbiter (
      .enable   (!seq_busy),
      .vec_req  (vec_valid),
      .call_req (call_valid),
      .ret_req  (ret_valid),
      .jmp_req  (jmp_valid),
      .adv_req  (adv_valid),
      .grant    (grant)
   );

   assign next_seq_pc = pc_q + PC_W'(instr_len);
   // An interrupt resumes the instruction at pc; a call resumes after itself
   assign ret_addr    = (grant == GR_VEC) ? pc_q : next_seq_pc;

   pcs_seq #(
      .PC_W     (PC_W),
      .BYTE_W   (BYTE_W),
      .SP_W     (SP_W),
      .SP_RST   (SP_RST),
      .LO_FIRST (LO_FIRST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .grant      (grant),
      .ret_addr   (ret_addr),
      .sp_wr_en   (sp_wr_en),
      .sp_wr_data (sp_wr_data),
      .rd_byte    (mem_rdata),
      .sp_q       (sp_q),
      .busy       (seq_busy),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .pop_done   (pop_done),
      .pop_pc     (pop_pc)
   );

   pcs_stack_ram #(
      .ADDR_W (SP_W),
      .DATA_W (BYTE_W)
   ) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   always_comb begin
      if (pop_done) begin
         pc_d = pop_pc;
      end else begin
         unique case (grant)
            GR_VEC:  pc_d = vec_target;
            GR_CALL: pc_d = call_target;
            GR_JMP:  pc_d = jmp_target;
            GR_ADV:  pc_d = next_seq_pc;
            default: pc_d = pc_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc        = pc_q;
   assign sp        = sp_q;
   assign busy      = seq_busy;
   assign stk_we    = mem_we;
   assign stk_addr  = mem_addr;
   assign stk_wdata = mem_wdata;
   assign stk_rdata = mem_rdata;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
   parameter int              PC_W   = 16,
   parameter int              SP_W   = 8,
   parameter int              LEN_W  = 2,
   parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv_valid,
   input logic [LEN_W-1:0] instr_len,
   input logic             jmp_valid,
   input logic [PC_W-1:0]  jmp_target,
   input logic             call_valid,
   input logic [PC_W-1:0]  call_target,
   input logic             ret_valid,
   input logic             vec_valid,
   input logic [PC_W-1:0]  vec_target,
   input logic             sp_wr_en,
   input logic [SP_W-1:0]  sp_wr_data,
   input logic [PC_W-1:0]  pc,
   input logic [SP_W-1:0]  sp,
   input logic             busy,
   input logic             stk_we,
   input logic [SP_W-1:0]  stk_addr
);

   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == '0 && sp == SP_RST && !busy));

   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && adv_valid && !jmp_valid && !call_valid && !ret_valid && !vec_valid)
      |=> pc == $past(pc) + PC_W'($past(instr_len)));

   a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && jmp_valid && !call_valid && !ret_valid && !vec_valid)
      |=> pc == $past(jmp_target));

   a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && call_valid && !vec_valid) |=> (pc == $past(call_target) && busy));

   a_r5_vector_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && vec_valid) |=> (pc == $past(vec_target) && busy));

   a_r6_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !stk_we) |=> sp == $past(sp) - ONE);

   a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r8_push2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stk_we) |=> pc == $past(pc));

   a_r9_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sp_wr_en && !vec_valid && !call_valid && !ret_valid)
      |=> sp == $past(sp_wr_data));

   a_r10_push_increments: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |=> sp == $past(sp) + ONE);

   a_r11_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |-> stk_addr == sp + ONE);

   a_r11_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !stk_we |-> stk_addr == sp);

endmodule

bind pc_stack_unit pcs_checker #(
   .PC_W   (PC_W),
   .SP_W   (SP_W),
   .LEN_W  (LEN_W),
   .SP_RST (SP_RST)
) u_pcs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .adv_valid   (adv_valid),
   .instr_len   (instr_len),
   .jmp_valid   (jmp_valid),
   .jmp_target  (jmp_target),
   .call_valid  (call_valid),
   .call_target (call_target),
   .ret_valid   (ret_valid),
   .vec_valid   (vec_valid),
   .vec_target  (vec_target),
   .sp_wr_en    (sp_wr_en),
   .sp_wr_data  (sp_wr_data),
   .pc          (pc),
   .sp          (sp),
   .busy        (busy),
   .stk_we      (stk_we),
   .stk_addr    (stk_addr)
);

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv_valid, jmp_valid, call_valid, ret_valid, vec_valid, sp_wr_en;
   logic [1:0]  instr_len;
   logic [15:0] jmp_target, call_target, vec_target;
   logic [7:0]  sp_wr_data;
   logic [15:0] pc;
   logic [7:0]  sp;
   logic        busy, stk_we;
   logic [7:0]  stk_addr, stk_wdata, stk_rdata;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // Behavioural reference state
   int mpc, msp, mstate, mheld, depth;
   int mmem [int];

   always #(CLK_NS / 2) clk = ~clk;

   pc_stack_unit i_pc_stack_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv_valid   (adv_valid),
      .instr_len   (instr_len),
      .jmp_valid   (jmp_valid),
      .jmp_target  (jmp_target),
      .call_valid  (call_valid),
      .call_target (call_target),
      .ret_valid   (ret_valid),
      .vec_valid   (vec_valid),
      .vec_target  (vec_target),
      .sp_wr_en    (sp_wr_en),
      .sp_wr_data  (sp_wr_data),
      .pc          (pc),
      .sp          (sp),
      .busy        (busy),
      .stk_we      (stk_we),
      .stk_addr    (stk_addr),
      .stk_wdata   (stk_wdata),
      .stk_rdata   (stk_rdata)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock of stimulus; outputs compared against the model on every clock
   task automatic do_cycle(input bit a, input int ln, input bit j, input int jt,
                           input bit c, input int ct, input bit r, input bit v,
                           input int vt, input bit sw, input int sd, input string tag);
      int g, ra, e_we, e_addr, e_wd;
      adv_valid   = a;   instr_len   = 2'(ln);
      jmp_valid   = j;   jmp_target  = 16'(jt);
      call_valid  = c;   call_target = 16'(ct);
      ret_valid   = r;
      vec_valid   = v;   vec_target  = 16'(vt);
      sp_wr_en    = sw;  sp_wr_data  = 8'(sd);
      #1;
      g = 0;
      if (mstate == 0) begin
         if (v)      g = 5;
         else if (c) g = 4;
         else if (r) g = 3;
         else if (j) g = 2;
         else if (a) g = 1;
      end
      ra     = (g == 5) ? mpc : ((mpc + ln) % 65536);
      e_we   = (g >= 4 || mstate == 1) ? 1 : 0;
      e_addr = e_we ? ((msp + 1) % 256) : msp;
      e_wd   = (mstate == 1) ? mheld : (ra % 256);
      chk(tag, "busy", int'(busy), (mstate != 0) ? 1 : 0);
      chk({tag, "/R11"}, "stk_we", int'(stk_we), e_we);
      chk({tag, "/R11"}, "stk_addr", int'(stk_addr), e_addr);
      if (e_we != 0) chk({tag, "/R11"}, "stk_wdata", int'(stk_wdata), e_wd);
      else if (mmem.exists(e_addr)) chk({tag, "/R11"}, "stk_rdata", int'(stk_rdata), mmem[e_addr]);
      // Advance the model
      if (mstate == 1) begin
         msp = (msp + 1) % 256; mmem[msp] = mheld; depth++; mstate = 0;
      end else if (mstate == 2) begin
         mpc = mheld * 256 + mmem[msp]; msp = (msp + 255) % 256; depth--; mstate = 0;
      end else begin
         case (g)
            5, 4: begin
               msp = (msp + 1) % 256; mmem[msp] = ra % 256; mheld = ra / 256;
               depth++; mstate = 1; mpc = (g == 5) ? vt : ct;
            end
            3: begin
               mheld = mmem[msp]; msp = (msp + 255) % 256; depth--; mstate = 2;
            end
            2: mpc = jt;
            1: mpc = (mpc + ln) % 65536;
            default: ;
         endcase
         if (g < 3 && sw) begin msp = sd; depth = 0; end
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "pc", int'(pc), mpc);
      chk(tag, "sp", int'(sp), msp);
   endtask

   task automatic idle(input string tag);
      do_cycle(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic step(input int ln, input string tag);
      do_cycle(1, ln, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic jump(input int t, input string tag);
      do_cycle(0, 1, 1, t, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic call2(input int t, input int ln, input string tag);
      do_cycle(0, ln, 0, 0, 1, t, 0, 0, 0, 0, 0, tag);
      idle(tag);
   endtask
   task automatic vec2(input int t, input string tag);
      do_cycle(0, 1, 0, 0, 0, 0, 0, 1, t, 0, 0, tag);
      idle(tag);
   endtask
   task automatic ret2(input string tag);
      do_cycle(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, tag);
      idle(tag);
   endtask
   task automatic spw(input int d, input string tag);
      do_cycle(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, d, tag);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      adv_valid = 0; jmp_valid = 0; call_valid = 0; ret_valid = 0; vec_valid = 0;
      sp_wr_en = 0; instr_len = 0; jmp_target = 0; call_target = 0; vec_target = 0;
      sp_wr_data = 0;
      mpc = 0; msp = 7; mstate = 0; mheld = 0; depth = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "pc", int'(pc), 0);
      chk("R1", "sp", int'(sp), 7);
      chk("R1", "busy", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pc after release", int'(pc), 0);
      chk("R1", "sp after release", int'(sp), 7);

      // R2: every length, then wrap of the counter
      step(1, "R2"); step(2, "R2"); step(3, "R2");
      jump(16'hFFFF, "R3");
      step(2, "R2");
      // R3
      jump(16'h1234, "R3");
      // R4: nested calls; R6 returns
      call2(16'h2000, 3, "R4");
      step(2, "R2");
      call2(16'h3000, 2, "R4");
      ret2("R6");
      ret2("R6");
      // R5: vector saves the unchanged pc
      vec2(16'h0033, "R5");
      ret2("R6");
      // R7: coincident requests
      do_cycle(1, 2, 1, 16'h4000, 1, 16'h5000, 1, 1, 16'h0003, 0, 0, "R7");
      idle("R7");
      do_cycle(1, 1, 1, 16'h4000, 1, 16'h5000, 1, 0, 0, 0, 0, "R7");
      idle("R7");
      do_cycle(1, 3, 1, 16'h4444, 0, 0, 1, 0, 0, 0, 0, "R7");
      idle("R7");
      do_cycle(1, 3, 1, 16'h4444, 0, 0, 0, 0, 0, 0, 0, "R7");
      // R8: everything driven during the second stack cycle
      do_cycle(0, 1, 0, 0, 1, 16'h6000, 0, 0, 0, 0, 0, "R8");
      do_cycle(1, 3, 1, 16'h7777, 1, 16'h8888, 1, 1, 16'h9999, 1, 16'h42, "R8");
      do_cycle(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
      do_cycle(1, 3, 1, 16'h7777, 1, 16'h8888, 1, 1, 16'h9999, 1, 16'h42, "R8");
      idle("R8");
      // R9: write with a jump takes effect; write with a call is dropped
      do_cycle(0, 1, 1, 16'h0100, 0, 0, 0, 0, 0, 1, 16'h40, "R9");
      do_cycle(0, 2, 0, 0, 1, 16'h0200, 0, 0, 0, 1, 16'h90, "R9");
      idle("R9");
      ret2("R9");
      // R10: push pair across 0xFF -> 0x00, pop back across the boundary
      spw(16'hFE, "R10");
      call2(16'h0ABC, 3, "R10");
      ret2("R10");
      spw(16'hFF, "R10");
      vec2(16'h0777, "R10");
      ret2("R10");
      idle("R10");

      // Mixed traffic with returns only over saved addresses (R7, R11)
      depth = 0;
      for (int k = 0; k < 600; k++) begin
         bit a, j, c, r, v;
         int ln;
         a = $urandom_range(0, 1) != 0;
         j = $urandom_range(0, 3) == 0;
         c = $urandom_range(0, 5) == 0;
         v = $urandom_range(0, 9) == 0;
         r = $urandom_range(0, 3) == 0;
         ln = $urandom_range(1, 3);
         if (mstate == 0 && depth < 2) r = 0;
         if (depth > 200) begin c = 0; v = 0; end
         do_cycle(a, ln, j, $urandom_range(0, 65535), c, $urandom_range(0, 65535),
                  r, v, $urandom_range(0, 65535), 0, 0, "R7");
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule